// File: doc/BRIEF.md
# Quasi-Resonant Switch Timing Controller

This block decides the turn-on and turn-off instants of the primary switch in a quasi-resonant flyback converter. While the switch is off it counts the valleys of the drain ringing, reported as falling crossings of the auxiliary-winding voltage through a zero-crossing comparator. It turns the switch back on once that count reaches a skip count supplied by a neighbouring valley-count selector. A ringing-suppression interval blocks turn-on right after turn-off. The interval is short when the winding voltage is still high and long when it is low. A period watchdog forces a turn-on when too few valleys appear.

While the switch is on, the block ends the pulse on a PWM comparator trip, on a current-limit trip seen after a leading-edge blanking window, or when the on-time limit is reached. All comparator inputs are already synchronized to the system clock. A protection enable from the surrounding protection logic holds the gate low and parks every counter and timer while it is deasserted. All times are parameters counted in system-clock cycles, and the gate request is a registered output.

Top module: `qr_switch_timer`

## Requirements
- R1: The valley counter increments by one on each rising edge of `zc_low` seen while the gate is low. It saturates at 7, it is cleared whenever the gate is high, and edges seen while the gate is high are not counted.
- R2: After the suppression interval has elapsed, the gate goes high on the clock edge after the cycle in which the valley count is greater than or equal to `skip_cnt`. While the count is below `skip_cnt` it stays low, unless R5 applies.
- R3: If `rs_high` is 1 in the last cycle of the short window, the short interval applies. The earliest turn-on is then `RS_SHORT+1` clock edges after the edge that lowered the gate or followed the rise of `prot_en`.
- R4: If `rs_high` is 0 in that last cycle, the long interval applies and the earliest turn-on is `RS_LONG+1` edges after that edge. Later changes of `rs_high` do not shorten it.
- R5: `PER_MAX` clock edges after the last turn-on, or after `prot_en` rises, the gate turns on whatever the valley count and skip count are.
- R6: A gate pulse that no trip ends lasts exactly `ON_MAX` cycles.
- R7: `ilim_trip` is ignored during the first `LEB` cycles of a pulse. When it is held high from turn-on, the pulse lasts `LEB+1` cycles.
- R8: `pwm_trip` high while the gate is high lowers the gate on the next edge. Held high from turn-on, it gives a one-cycle pulse.
- R9: While `prot_en` is 0 the gate is low from the next edge on. When `prot_en` rises, timing restarts as after a fresh turn-off with an empty valley count.
- R10: During reset the gate request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Switching enable from the protection logic |
| zc_low | input | 1 | Winding voltage below the zero-crossing threshold (rising edge marks a valley) |
| rs_high | input | 1 | Winding voltage above the suppression threshold |
| pwm_trip | input | 1 | PWM comparator: sensed current reached the regulation level |
| ilim_trip | input | 1 | Peak current-limit comparator |
| skip_cnt | input | 3 | Number of valleys to wait before turn-on |
| gate_req | output | 1 | Gate drive request |

## Verification
The bench builds the block with `RS_SHORT=4`, `RS_LONG=48`, `PER_MAX=120`, `ON_MAX=10` and `LEB=3`. At these values every skip count from 1 to 7 can be reached by pulses placed after the short interval, and the watchdog does not interfere. Nine valleys fit inside one long interval, which exposes a counter that wraps instead of saturating. The long interval is still shorter than the period limit, so both suppression lengths can be measured to the exact edge. Blanking, trips and forced periods are all short enough to sweep and to time edge by edge.

// File: rtl/qr_pkg.sv
package qr_pkg;
  localparam int VCNT_W = 3;
  localparam logic [VCNT_W-1:0] VCNT_MAX = '1;
  typedef logic [VCNT_W-1:0] vcount_t;
endpackage

// File: rtl/qr_sat_timer.sv
module qr_sat_timer #(
  parameter int LAST = 7,
  localparam int W = (LAST < 1) ? 1 : $clog2(LAST + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= '0;
    else if (clr)           age <= '0;
    else if (age != LAST_V) age <= age + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (age == $past(age) + 1'b1) || (age == LAST_V)); // R6
endmodule

// File: rtl/qr_valley_count.sv
module qr_valley_count
  import qr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    zc_low,
  output vcount_t count
);
  logic zc_d;
  logic zc_edge;

  assign zc_edge = zc_low & ~zc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_d <= 1'b0;
    else        zc_d <= zc_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           count <= '0;
    else if (clr)                         count <= '0;
    else if (zc_edge && count != VCNT_MAX) count <= count + 1'b1;
  end

  AST_VCNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count >= $past(count)); // R1
  AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count - $past(count)) <= 3'd1); // R1
endmodule

// File: rtl/qr_ring_suppress.sv
module qr_ring_suppress #(
  parameter int RS_SHORT = 28,
  parameter int RS_LONG  = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rs_high,
  output logic done
);
  localparam int RS_W = $clog2(RS_LONG + 1);
  localparam logic [RS_W-1:0] SHORT_V = RS_W'(RS_SHORT);
  localparam logic [RS_W-1:0] SAMPLE_V = RS_W'(RS_SHORT - 1);
  localparam logic [RS_W-1:0] LONG_V = RS_W'(RS_LONG);

  logic [RS_W-1:0] age;
  logic            short_ok;

  qr_sat_timer #(.LAST(RS_LONG)) u_age (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .age  (age)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 short_ok <= 1'b0;
    else if (clr)               short_ok <= 1'b0;
    else if (age == SAMPLE_V)   short_ok <= rs_high;
  end

  assign done = (short_ok && age >= SHORT_V) || (age == LONG_V);

  AST_RS_CHOICE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && age > SHORT_V) |-> $stable(short_ok)); // R4
endmodule

// File: rtl/qr_switch_timer.sv
module qr_switch_timer
  import qr_pkg::*;
#(
  parameter int RS_SHORT = 28,
  parameter int RS_LONG  = 250,
  parameter int PER_MAX  = 500,
  parameter int ON_MAX   = 300,
  parameter int LEB      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_en,
  input  logic               zc_low,
  input  logic               rs_high,
  input  logic               pwm_trip,
  input  logic               ilim_trip,
  input  logic [VCNT_W-1:0]  skip_cnt,
  output logic               gate_req
);
  localparam int ON_W  = (ON_MAX  < 2) ? 1 : $clog2(ON_MAX);
  localparam int PER_W = (PER_MAX < 2) ? 1 : $clog2(PER_MAX);
  localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(ON_MAX - 1);
  localparam logic [ON_W-1:0]  LEB_V    = ON_W'(LEB);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PER_MAX - 1);

  logic [ON_W-1:0]  on_age;
  logic [PER_W-1:0] per_age;
  vcount_t          vcount;
  logic             rs_done;
  logic             turn_on;
  logic             turn_off;
  logic             per_force;
  logic             gate_d;

  qr_valley_count u_valley (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (gate_req | ~prot_en),
    .zc_low(zc_low),
    .count (vcount)
  );

  qr_ring_suppress #(.RS_SHORT(RS_SHORT), .RS_LONG(RS_LONG)) u_rs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (gate_req | ~prot_en),
    .rs_high(rs_high),
    .done   (rs_done)
  );

  qr_sat_timer #(.LAST(ON_MAX - 1)) u_on (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~gate_req),
    .age  (on_age)
  );

  qr_sat_timer #(.LAST(PER_MAX - 1)) u_per (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (turn_on | ~prot_en),
    .age  (per_age)
  );

  assign per_force = (per_age == PER_LAST);

  always_comb begin
    turn_on  = prot_en && !gate_req &&
               ((rs_done && vcount >= skip_cnt) || per_force);
    turn_off = gate_req &&
               (pwm_trip || (ilim_trip && on_age >= LEB_V) || on_age == ON_LAST);
    gate_d   = prot_en && (gate_req ? !turn_off : turn_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_req <= 1'b0;
    else        gate_req <= gate_d;
  end

  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> !gate_req); // R9
  AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_req && on_age == ON_LAST) |=> !gate_req); // R6
  AST_LEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && gate_req && on_age < LEB_V && !pwm_trip && on_age != ON_LAST)
      |=> gate_req); // R7
  AST_PWM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_req && pwm_trip) |=> !gate_req); // R8
  AST_PERIOD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && !gate_req && per_force) |=> gate_req); // R5
  AST_RS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_req && !rs_done && !per_force) |=> !gate_req); // R3
  AST_SKIP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_req && vcount < skip_cnt && !per_force) |=> !gate_req); // R2
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !gate_req); // R10
endmodule

// File: tb/qr_switch_timer_test.sv
module qr_switch_timer_test;
  localparam int CLK_NS   = 10;
  localparam int RS_SHORT = 4;
  localparam int RS_LONG  = 48;
  localparam int PER_MAX  = 120;
  localparam int ON_MAX   = 10;
  localparam int LEB      = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       zc = 1'b0;
  logic       rsh = 1'b0;
  logic       pwm = 1'b0;
  logic       ilim = 1'b0;
  logic [2:0] skip = 3'd0;
  logic       gate;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  qr_switch_timer #(
    .RS_SHORT(RS_SHORT), .RS_LONG(RS_LONG), .PER_MAX(PER_MAX),
    .ON_MAX(ON_MAX), .LEB(LEB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .prot_en(en), .zc_low(zc), .rs_high(rsh),
    .pwm_trip(pwm), .ilim_trip(ilim), .skip_cnt(skip), .gate_req(gate)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input int s, input logic r);
    en = 1'b0; zc = 1'b0; pwm = 1'b0; ilim = 1'b0;
    repeat (2) @(negedge clk);
    skip = 3'(s); rsh = r; en = 1'b1;
  endtask

  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n = n + 1;
      if (gate) break;
    end
  endtask

  task automatic high_width(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (gate) w = w + 1;
      else break;
    end
  endtask

  task automatic valley(output logic g);
    zc = 1'b1;
    @(negedge clk);
    zc = 1'b0;
    @(negedge clk);
    g = gate;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int n;
    int w;
    logic g;
    int bad;

    repeat (3) @(negedge clk);
    chk("R10 gate in reset", int'(gate), 0);
    rst_n = 1'b1;

    // R3 / R4: both suppression lengths with an empty skip
    for (int r = 0; r < 2; r++) begin
      restart(0, logic'(r));
      wait_rise(300, n);
      chk(r ? "R3 short suppression" : "R4 long suppression", n,
          r ? RS_SHORT + 1 : RS_LONG + 1);
    end

    // R4: flag falls just before the sample point
    restart(0, 1'b1);
    repeat (RS_SHORT - 1) @(negedge clk);
    rsh = 1'b0;
    wait_rise(300, n);
    chk("R4 late drop selects long", n + RS_SHORT - 1, RS_LONG + 1);

    // R4: flag rises after the sample point
    restart(0, 1'b0);
    repeat (RS_SHORT) @(negedge clk);
    rsh = 1'b1;
    wait_rise(300, n);
    chk("R4 late rise keeps long", n + RS_SHORT, RS_LONG + 1);

    // R2: sweep of skip counts, valleys after the short interval
    for (int s = 1; s < 8; s++) begin
      restart(s, 1'b1);
      repeat (10) @(negedge clk);
      for (int i = 1; i <= s; i++) begin
        valley(g);
        chk($sformatf("R2 skip=%0d valley=%0d", s, i), int'(g), (i == s) ? 1 : 0);
      end
    end

    // R1: saturation at 7 while nine valleys arrive in the long window
    restart(7, 1'b0);
    for (int i = 0; i < 9; i++) valley(g);
    wait_rise(300, n);
    chk("R1 saturating valley count", n + 36, RS_LONG + 1);

    // R1: count cleared at turn-on, valleys during on-time ignored
    restart(3, 1'b1);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) valley(g);
    chk("R1 third valley turns on", int'(gate), 1);
    skip = 3'd2;
    valley(g);
    while (gate) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R1 count cleared after on", int'(gate), 0);
    valley(g);
    chk("R1 first new valley", int'(g), 0);
    valley(g);
    chk("R1 second new valley", int'(g), 1);

    // R5 / R6: no valleys, forced periods and full-length pulses
    restart(7, 1'b1);
    wait_rise(300, n);
    chk("R5 first forced turn-on", n, PER_MAX);
    high_width(w);
    chk("R6 max on-time", w, ON_MAX);
    wait_rise(300, n);
    chk("R5 forced period", n + w, PER_MAX);

    // R7: current limit held high from turn-on
    restart(0, 1'b1);
    ilim = 1'b1;
    wait_rise(300, n);
    high_width(w);
    chk("R7 blanked current limit", w, LEB + 1);

    // R8: PWM trip held high and PWM trip mid-pulse
    restart(0, 1'b1);
    pwm = 1'b1;
    wait_rise(300, n);
    high_width(w);
    chk("R8 held pwm trip", w, 1);
    restart(0, 1'b1);
    wait_rise(300, n);
    @(negedge clk);
    pwm = 1'b1;
    @(negedge clk);
    chk("R8 mid-pulse pwm trip", int'(gate), 0);
    pwm = 1'b0;

    // R9: enable low forces the gate low and holds it there
    restart(0, 1'b1);
    wait_rise(300, n);
    en = 1'b0;
    bad = 0;
    for (int i = 0; i < PER_MAX + 30; i++) begin
      @(negedge clk);
      if (gate) bad = bad + 1;
    end
    chk("R9 gate low while disabled", bad, 0);
    en = 1'b1;
    wait_rise(300, n);
    chk("R9 fresh start on enable", n, RS_SHORT + 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule